// File: doc/BRIEF.md
# Real-Time-Clock Alarm Comparator

This unit compares a programmable alarm time against the running BCD time of a real-time clock. It raises an interrupt when they match. Software programs four alarm fields through a byte-wide register port: seconds, minutes, hours and day of month. Bit 7 of each field is a mask bit. The four mask bits together select one of five repeat rates: once a month, once a day, once an hour, once a minute or once a second. The repeat rate decides which fields take part in the comparison.

The surrounding clock logic supplies the current seconds, minutes, hours and date in BCD, along with a strobe that pulses once per second. The unit does not keep time itself. On each strobe it evaluates the match, sets a sticky alarm flag and, if the alarm enable bit is set, emits a one-cycle interrupt pulse. Each alarm-field write is range-checked on its decoded BCD value. A write that is out of range is dropped, and the field keeps its previous contents.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, every register address reads 0x00 and `irqOut` is low.
- R2: Addresses 0 (alarm seconds) and 1 (alarm minutes) accept a write only if the value decodes to at most 59. The decoded value is bits 6:4 times ten plus bits 3:0. An accepted write stores the whole byte, including bit 7, and reads it back unchanged. A rejected write leaves the old byte in place.
- R3: Address 2 (alarm hours) accepts a write only if bits 5:4 times ten plus bits 3:0 is at most 23. Storage and read-back follow the rules of R2.
- R4: Address 3 (alarm date) rejects a write when bit 4 times ten plus bits 3:0 equals zero, and accepts any other value. Storage and read-back follow the rules of R2.
- R5: With all four mask bits clear (monthly), a match requires four fields to be equal: seconds and minutes on bits 6:0, and hours and date on bits 5:0.
- R6: With only the date mask bit set (daily), a match compares seconds, minutes and hours and ignores the date.
- R7: With the date and hours mask bits set (hourly), a match compares seconds and minutes only.
- R8: With the date, hours and minutes mask bits set (per minute), a match compares seconds only.
- R9: Any other mask combination, including all four set or only the seconds mask set, matches on every tick.
- R10: Matching is evaluated only in a cycle where `secTick` is high. An enabled match drives `irqOut` high for exactly the one cycle after that tick edge.
- R11: Address 4 is the interrupt register. It stores and reads back the full byte, and its bit 7 enables `irqOut`. With bit 7 clear, `irqOut` stays low.
- R12: Address 5 is the flag register. Its bit 6 is set by any match, whether or not the interrupt is enabled. A read of address 5 clears the bit, but a match in the same cycle takes priority. Writes to address 5 have no effect.
- R13: Addresses 6 and 7 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (needed for the flag clear) |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, combinational from `regAddr` |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours, BCD |
| curDate | input | 8 | Current day of month, BCD |
| secTick | input | 1 | One-cycle strobe once per second |
| irqOut | output | 1 | Alarm interrupt pulse |

## Verification
A wrong mask decode or a wrong field compare shows up on `irqOut` in the cycle right after the tick that should have fired, or should not have. A stuck or lost flag shows up on the next read of address 5. A range check that accepts or rejects the wrong value is visible on the next read of the alarm field. The field either fails to change, or takes a value it should have refused. None of these faults stays hidden for longer than one tick or one read-back.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int NUM_FIELDS = 4;

  // alarm fields sit at ascending addresses starting here
  localparam logic [ADDR_W-1:0] ADR_FIELD0 = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_IEN    = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_FLAG   = 3'd5;

  localparam int MASK_BIT = 7;
  localparam int IEN_BIT  = 7;
  localparam int FLAG_BIT = 6;

  // field indices
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DATE = 3;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MIN,
    RPT_SEC
  } rptMode_e;

  typedef struct packed {
    logic ldSec;
    logic ldMin;
    logic ldHour;
    logic ldDate;
    logic ldIen;
    logic clrFlag;
    logic setFlag;
    logic fireIrq;
  } strobe_t;

  // bits of a field that take part in the time comparison
  function automatic logic [DATA_W-1:0] cmpMask(input int idx);
    if (idx == F_SEC || idx == F_MIN) return 8'h7F;
    return 8'h3F;
  endfunction

  // tens digit of tensW bits above a 4-bit units digit
  function automatic logic [7:0] bcdDecode(input logic [7:0] v, input int tensW);
    logic [7:0] tens;
    case (tensW)
      3:       tens = {5'd0, v[6:4]};
      2:       tens = {6'd0, v[5:4]};
      default: tens = {7'd0, v[4]};
    endcase
    return tens * 8'd10 + {4'd0, v[3:0]};
  endfunction

  function automatic logic fieldAccept(input int idx, input logic [7:0] v);
    case (idx)
      F_SEC, F_MIN: return bcdDecode(v, 3) <= 8'd59;
      F_HOUR:       return bcdDecode(v, 2) <= 8'd23;
      default:      return bcdDecode(v, 1) != 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic                  regWe,
  input  logic                  regRe,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  input  logic [NUM_FIELDS-1:0] maskBits,
  input  logic [NUM_FIELDS-1:0] fieldEq,
  input  logic                  ienBit,
  input  logic                  secTick,
  output strobe_t               strobe
);

  rptMode_e              rptMode;
  logic [NUM_FIELDS-1:0] needVec;
  logic [NUM_FIELDS-1:0] ldVec;
  logic                  matchNow;

  // mask pattern {date,hour,min,sec} -> repeat rate
  always_comb begin
    case (maskBits)
      4'b0000: rptMode = RPT_MONTH;
      4'b1000: rptMode = RPT_DAY;
      4'b1100: rptMode = RPT_HOUR;
      4'b1110: rptMode = RPT_MIN;
      default: rptMode = RPT_SEC;
    endcase
  end

  always_comb begin
    case (rptMode)
      RPT_MONTH: needVec = 4'b1111;
      RPT_DAY:   needVec = 4'b0111;
      RPT_HOUR:  needVec = 4'b0011;
      RPT_MIN:   needVec = 4'b0001;
      default:   needVec = 4'b0000;
    endcase
  end

  assign matchNow = &(fieldEq | ~needVec);

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fieldLoad
    localparam logic [ADDR_W-1:0] FIELD_ADR = ADR_FIELD0 + ADDR_W'(g);
    assign ldVec[g] = regWe && (regAddr == FIELD_ADR) && fieldAccept(g, regWdata);
  end

  always_comb begin
    strobe         = '0;
    strobe.ldSec   = ldVec[F_SEC];
    strobe.ldMin   = ldVec[F_MIN];
    strobe.ldHour  = ldVec[F_HOUR];
    strobe.ldDate  = ldVec[F_DATE];
    strobe.ldIen   = regWe && (regAddr == ADR_IEN);
    strobe.clrFlag = regRe && (regAddr == ADR_FLAG);
    strobe.setFlag = secTick && matchNow;
    strobe.fireIrq = secTick && matchNow && ienBit;
  end

endmodule

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             strobe,
  input  logic [ADDR_W-1:0]                   regAddr,
  input  logic [DATA_W-1:0]                   regWdata,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0]   curTime,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0]   alarmQ,
  output logic [DATA_W-1:0]                   ienQ,
  output logic                                flagQ,
  output logic                                irqOut,
  output logic [DATA_W-1:0]                   regRdata,
  output logic [NUM_FIELDS-1:0]               fieldEq,
  output logic [NUM_FIELDS-1:0]               maskBits
);

  logic [NUM_FIELDS-1:0] ldVec;
  assign ldVec = {strobe.ldDate, strobe.ldHour, strobe.ldMin, strobe.ldSec};

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam logic [DATA_W-1:0] CMP = cmpMask(g);
    always_ff @(posedge clk) begin
      if (!rstN)          alarmQ[g] <= '0;
      else if (ldVec[g])  alarmQ[g] <= regWdata;
    end
    assign fieldEq[g]  = (alarmQ[g] & CMP) == (curTime[g] & CMP);
    assign maskBits[g] = alarmQ[g][MASK_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienQ   <= '0;
      flagQ  <= 1'b0;
      irqOut <= 1'b0;
    end else begin
      if (strobe.ldIen) ienQ <= regWdata;
      if (strobe.setFlag)      flagQ <= 1'b1;
      else if (strobe.clrFlag) flagQ <= 1'b0;
      irqOut <= strobe.fireIrq;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr < ADR_FIELD0 + ADDR_W'(NUM_FIELDS)) regRdata = alarmQ[regAddr[1:0]];
    else if (regAddr == ADR_IEN)  regRdata = ienQ;
    else if (regAddr == ADR_FLAG) regRdata[FLAG_BIT] = flagQ;
  end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic [7:0]        curSec,
  input  logic [7:0]        curMin,
  input  logic [7:0]        curHour,
  input  logic [7:0]        curDate,
  input  logic              secTick,
  output logic              irqOut
);

  strobe_t                              strobe;
  logic [NUM_FIELDS-1:0][DATA_W-1:0]    curTime;
  logic [NUM_FIELDS-1:0][DATA_W-1:0]    alarmQ;
  logic [DATA_W-1:0]                    ienQ;
  logic                                 flagQ;
  logic [NUM_FIELDS-1:0]                fieldEq;
  logic [NUM_FIELDS-1:0]                maskBits;

  assign curTime = {curDate, curHour, curMin, curSec};

  rtc_alarm_ctrl u_ctrl (
    .regWe    (regWe),
    .regRe    (regRe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .maskBits (maskBits),
    .fieldEq  (fieldEq),
    .ienBit   (ienQ[IEN_BIT]),
    .secTick  (secTick),
    .strobe   (strobe)
  );

  rtc_alarm_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .curTime  (curTime),
    .alarmQ   (alarmQ),
    .ienQ     (ienQ),
    .flagQ    (flagQ),
    .irqOut   (irqOut),
    .regRdata (regRdata),
    .fieldEq  (fieldEq),
    .maskBits (maskBits)
  );

endmodule

// File: rtl/rtc_alarm_checker.sv
module rtc_alarm_checker
  import rtc_alarm_pkg::*;
(
  input logic                              clk,
  input logic                              rstN,
  input logic                              regWe,
  input logic                              regRe,
  input logic [2:0]                        regAddr,
  input logic [7:0]                        regWdata,
  input logic                              secTick,
  input logic                              irqOut,
  input logic                              flagQ,
  input logic [DATA_W-1:0]                 ienQ,
  input logic [NUM_FIELDS-1:0][DATA_W-1:0] alarmQ,
  input strobe_t                           strobe
);

  logic [7:0] hourVal;
  assign hourVal = {6'd0, regWdata[5:4]} * 8'd10 + {4'd0, regWdata[3:0]};

  a_r10_irq_follows_tick: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(secTick));

  a_r12_irq_implies_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> flagQ);

  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ienQ[IEN_BIT] |=> !irqOut);

  a_r12_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == ADR_FLAG && !secTick) |=> !flagQ);

  a_r3_bad_hour_kept: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd2 && hourVal > 8'd23) |=> $stable(alarmQ[F_HOUR]));

  a_r2_single_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ldSec, strobe.ldMin, strobe.ldHour, strobe.ldDate, strobe.ldIen}));

endmodule

bind rtc_alarm_match rtc_alarm_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regRe    (regRe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .secTick  (secTick),
  .irqOut   (irqOut),
  .flagQ    (flagQ),
  .ienQ     (ienQ),
  .alarmQ   (alarmQ),
  .strobe   (strobe)
);

// File: tb/test_rtc_alarm_match.sv
`timescale 1ns/1ps
module test_rtc_alarm_match;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic       regRe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [7:0] curSec = '0, curMin = '0, curHour = '0, curDate = 8'h01;
  logic       secTick = 1'b0;
  logic       irqOut;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_match i_rtc_alarm_match (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .curSec(curSec), .curMin(curMin),
    .curHour(curHour), .curDate(curDate), .secTick(secTick), .irqOut(irqOut)
  );

  // {req, addr, wdata, expected read-back}
  localparam int NV = 19;
  localparam logic [26:0] VEC [NV] = '{
    {8'd2,  3'd0, 8'h59, 8'h59},
    {8'd2,  3'd0, 8'h60, 8'h59},
    {8'd2,  3'd0, 8'hD9, 8'hD9},
    {8'd2,  3'd0, 8'h7A, 8'hD9},
    {8'd2,  3'd1, 8'h30, 8'h30},
    {8'd2,  3'd1, 8'h5A, 8'h30},
    {8'd2,  3'd1, 8'h80, 8'h80},
    {8'd3,  3'd2, 8'h23, 8'h23},
    {8'd3,  3'd2, 8'h24, 8'h23},
    {8'd3,  3'd2, 8'h92, 8'h92},
    {8'd3,  3'd2, 8'hC0, 8'hC0},
    {8'd4,  3'd3, 8'h31, 8'h31},
    {8'd4,  3'd3, 8'h00, 8'h31},
    {8'd4,  3'd3, 8'h80, 8'h31},
    {8'd4,  3'd3, 8'h9F, 8'h9F},
    {8'd11, 3'd4, 8'h05, 8'h05},
    {8'd12, 3'd5, 8'hFF, 8'h00},
    {8'd13, 3'd6, 8'hAA, 8'h00},
    {8'd13, 3'd7, 8'h55, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic tick(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                      input logic [7:0] d, input logic expIrq, input string req);
    @(negedge clk);
    curSec = s; curMin = m; curHour = h; curDate = d; secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    chk(req, {7'd0, irqOut}, {7'd0, expIrq});
    @(negedge clk);
    chk({req, " pulse end"}, {7'd0, irqOut}, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset read", v, 8'h00);
    end
    chk("R1 reset irq", {7'd0, irqOut}, 8'h00);

    // table walk over writes and read-back: R2 R3 R4 R11 R12 R13
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      chk($sformatf("R%0d vector %0d", VEC[i][26:19], i), v, VEC[i][7:0]);
    end

    // R5 monthly
    wr(3'd0, 8'h10); wr(3'd1, 8'h20); wr(3'd2, 8'h05); wr(3'd3, 8'h15); wr(3'd4, 8'h80);
    rd(3'd5, v);
    tick(8'h10, 8'h20, 8'h05, 8'h15, 1'b1, "R5 monthly match");
    rd(3'd5, v); chk("R12 flag set", v, 8'h40);
    rd(3'd5, v); chk("R12 flag cleared by read", v, 8'h00);
    tick(8'h10, 8'h20, 8'h05, 8'h16, 1'b0, "R5 monthly date differs");

    // R6 daily
    wr(3'd3, 8'h95);
    tick(8'h10, 8'h20, 8'h05, 8'h03, 1'b1, "R6 daily any date");
    tick(8'h10, 8'h20, 8'h06, 8'h03, 1'b0, "R6 daily hour differs");

    // R7 hourly
    wr(3'd2, 8'h85);
    tick(8'h10, 8'h20, 8'h11, 8'h03, 1'b1, "R7 hourly any hour");
    tick(8'h11, 8'h20, 8'h11, 8'h03, 1'b0, "R7 hourly second differs");

    // R8 per minute
    wr(3'd1, 8'hA0);
    tick(8'h10, 8'h44, 8'h11, 8'h03, 1'b1, "R8 minute any minute");
    tick(8'h12, 8'h44, 8'h11, 8'h03, 1'b0, "R8 minute second differs");

    // R9 every second: all masks, then seconds mask alone
    wr(3'd0, 8'h90);
    tick(8'h33, 8'h44, 8'h11, 8'h03, 1'b1, "R9 all masks");
    wr(3'd1, 8'h20); wr(3'd2, 8'h05); wr(3'd3, 8'h15);
    tick(8'h00, 8'h00, 8'h00, 8'h01, 1'b1, "R9 seconds mask only");

    // R10 no tick, no interrupt even while matching
    @(negedge clk);
    curSec = 8'h10; curMin = 8'h20; curHour = 8'h05; curDate = 8'h15;
    rd(3'd5, v);
    repeat (3) @(negedge clk);
    chk("R10 no tick no irq", {7'd0, irqOut}, 8'h00);
    rd(3'd5, v); chk("R10 no tick no flag", v, 8'h00);

    // R11 enable off: no irq; R12 flag still set
    wr(3'd4, 8'h00);
    tick(8'h10, 8'h20, 8'h05, 8'h15, 1'b0, "R11 disabled irq");
    rd(3'd5, v); chk("R12 flag without enable", v, 8'h40);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule